// File: doc/BRIEF.md
# Low-Power Sleep Entry and Recovery Sequencer

This block sits beside the access logic of a synchronous memory and manages a low-power sleep state requested through a single active-high input. That input may change at any time with no relation to the clock, so it first crosses a chain of synchronising flops. The block then walks through a fixed entry window, the sleep state itself, and a fixed recovery window before it reports the interface as ready again.

The access logic uses four outputs. `ready_o` says that commands are sampled normally. `in_ignore_o` tells it to drop every command while asleep. `pwr_down_o` marks the low-power state. `q_hiz_o` forces the data outputs to high impedance from the first entry cycle until the last recovery cycle. During either window only deselect or read cycles are legal. A write presented to the block while a window is open sets a sticky protocol-error flag, which only reset clears.

The request may be withdrawn before sleep is reached. The block then goes straight to the recovery window and still serves its full length.

Top module: `snz_seq`

## Requirements
- R1: While reset is held and right after it is released, `ready_o`=1, `in_ignore_o`=0, `pwr_down_o`=0, `q_hiz_o`=0 and `proto_err_o`=0.
- R2: `sleep_req_i` passes through SYNC_STAGES (default 2) flops. With the default, the first rising edge that samples the request high is edge 1, and the block leaves the ready state at edge 3.
- R3: The entry window lasts ENTRY_CYC (default 2) cycles. In it `ready_o`=0, `in_ignore_o`=0, `pwr_down_o`=0 and `q_hiz_o`=1. It is followed by sleep if the request is still present.
- R4: In sleep `in_ignore_o`=1, `pwr_down_o`=1, `q_hiz_o`=1 and `ready_o`=0. This holds for as long as the synchronised request stays high.
- R5: A release is first sampled at edge 1. At edge 3 the block leaves sleep and enters a recovery window of EXIT_CYC (default 2) cycles, with outputs as in R3. After that window `ready_o`=1 and the other three status outputs are 0.
- R6: If the synchronised request falls during the entry window, the block enters the recovery window without visiting sleep and serves all EXIT_CYC cycles. When the release is seen on the same edge at which the entry window expires, the release takes priority.
- R7: A write (`acc_valid_i`=1 and `acc_write_i`=1) sampled on an edge where the block was in the entry or the recovery window sets `proto_err_o` on that edge. `proto_err_o` then stays 1 until reset.
- R8: Reads (`acc_write_i`=0) in either window, and writes while ready or asleep, leave `proto_err_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req_i | input | 1 | Sleep request, active high, asynchronous to clk |
| acc_valid_i | input | 1 | An access cycle is issued this cycle |
| acc_write_i | input | 1 | The issued cycle is a write (1) or a read (0) |
| ready_o | output | 1 | Commands are sampled normally |
| in_ignore_o | output | 1 | Access logic must drop commands |
| pwr_down_o | output | 1 | Low-power state reached |
| q_hiz_o | output | 1 | Data outputs forced to high impedance |
| proto_err_o | output | 1 | Sticky flag: write issued during a transition window |

## Verification
Two things can land on the same edge: the withdrawal of the request, and the expiry of the entry timer that would otherwise move the block into sleep. A request pulse two cycles long places the synchronised release exactly on the expiry edge. The bench expects four high-impedance cycles with no sleep cycle, then ready. A write driven on that same edge must raise the error flag in the very cycle the state changes to recovery. A one-cycle pulse and a long pulse bracket this case, each with its own expected cycle-by-cycle trace.

// File: rtl/snz_pkg.sv
package snz_pkg;

   typedef enum logic [1:0] {
      SNZ_READY = 2'd0,
      SNZ_ENTER = 2'd1,
      SNZ_SLEEP = 2'd2,
      SNZ_EXIT  = 2'd3
   } snz_state_e;

   function automatic int snz_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/snz_sync.sv
module snz_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 0) begin : g_bad_stages
      $error("snz_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
   end else begin : g_chain
      logic [STAGES-1:0] stage_q;
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         logic stage_d;
         if (i == 0) begin : g_first
            assign stage_d = d_i;
         end else begin : g_next
            assign stage_d = stage_q[i-1];
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[i] <= 1'b0;
            else        stage_q[i] <= stage_d;
         end
      end
      assign q_o = stage_q[STAGES-1];
   end

endmodule

// File: rtl/snz_timer.sv
module snz_timer #(
   parameter int ENTRY_CYC = 2,
   parameter int EXIT_CYC  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_entry_i,
   input  logic load_exit_i,
   output logic done_o
);
   import snz_pkg::*;

   localparam int MAX_LOAD = snz_max(ENTRY_CYC, EXIT_CYC) - 1;
   localparam int CW       = (MAX_LOAD < 1) ? 1 : $clog2(MAX_LOAD + 1);
   localparam logic [CW-1:0] ENTRY_LD = CW'(ENTRY_CYC - 1);
   localparam logic [CW-1:0] EXIT_LD  = CW'(EXIT_CYC - 1);

   if (ENTRY_CYC < 1) begin : g_bad_entry
      $error("snz_timer: ENTRY_CYC must be at least 1");
   end
   if (EXIT_CYC < 1) begin : g_bad_exit
      $error("snz_timer: EXIT_CYC must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load_entry_i)   cnt_q <= ENTRY_LD;
      else if (load_exit_i)    cnt_q <= EXIT_LD;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign done_o = (cnt_q == '0);

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(MAX_LOAD)) else $error("timer count out of range"); // R3

   AST_CNT_DESCENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_entry_i && !load_exit_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1)
      else $error("timer did not count down"); // R5

endmodule

// File: rtl/snz_fsm.sv
module snz_fsm (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_sync_i,
   input  logic                timer_done_i,
   output logic                load_entry_o,
   output logic                load_exit_o,
   output snz_pkg::snz_state_e state_o
);
   import snz_pkg::*;

   snz_state_e state_q, state_d;

   always_comb begin
      state_d      = state_q;
      load_entry_o = 1'b0;
      load_exit_o  = 1'b0;
      unique case (state_q)
         SNZ_READY: begin
            if (req_sync_i) begin
               state_d      = SNZ_ENTER;
               load_entry_o = 1'b1;
            end
         end
         SNZ_ENTER: begin
            if (!req_sync_i) begin
               state_d     = SNZ_EXIT;
               load_exit_o = 1'b1;
            end else if (timer_done_i) begin
               state_d = SNZ_SLEEP;
            end
         end
         SNZ_SLEEP: begin
            if (!req_sync_i) begin
               state_d     = SNZ_EXIT;
               load_exit_o = 1'b1;
            end
         end
         SNZ_EXIT: begin
            if (timer_done_i) state_d = SNZ_READY;
         end
         default: state_d = SNZ_READY;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SNZ_READY;
      else        state_q <= state_d;
   end

   assign state_o = state_q;

   AST_SLEEP_VIA_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SNZ_SLEEP && $past(state_q) != SNZ_SLEEP) |-> $past(state_q) == SNZ_ENTER)
      else $error("sleep reached without entry window"); // R3

   AST_WAKE_VIA_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SNZ_READY && $past(state_q) != SNZ_READY) |-> $past(state_q) == SNZ_EXIT)
      else $error("ready reached without recovery window"); // R5

   AST_EXIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SNZ_EXIT && !timer_done_i) |=> state_q == SNZ_EXIT)
      else $error("recovery window cut short"); // R6

endmodule

// File: rtl/snz_guard.sv
module snz_guard (
   input  logic                clk,
   input  logic                rst_n,
   input  snz_pkg::snz_state_e state_i,
   input  logic                acc_valid_i,
   input  logic                acc_write_i,
   output logic                err_o
);
   import snz_pkg::*;

   logic in_window;
   logic bad_write;
   logic err_q;

   assign in_window = (state_i == SNZ_ENTER) || (state_i == SNZ_EXIT);
   assign bad_write = in_window && acc_valid_i && acc_write_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         err_q <= 1'b0;
      else if (bad_write) err_q <= 1'b1;
   end

   assign err_o = err_q;

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q) else $error("error flag cleared without reset"); // R7

   AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_q) |-> $past(acc_valid_i && acc_write_i && state_i != SNZ_READY
                             && state_i != SNZ_SLEEP))
      else $error("error flag rose without an illegal write"); // R8

endmodule

// File: rtl/snz_seq.sv
module snz_seq #(
   parameter int SYNC_STAGES = 2,
   parameter int ENTRY_CYC   = 2,
   parameter int EXIT_CYC    = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_req_i,
   input  logic acc_valid_i,
   input  logic acc_write_i,
   output logic ready_o,
   output logic in_ignore_o,
   output logic pwr_down_o,
   output logic q_hiz_o,
   output logic proto_err_o
);
   import snz_pkg::*;

   logic       req_sync;
   logic       timer_done;
   logic       load_entry;
   logic       load_exit;
   snz_state_e state;

   snz_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (sleep_req_i),
      .q_o   (req_sync)
   );

   snz_timer #(.ENTRY_CYC(ENTRY_CYC), .EXIT_CYC(EXIT_CYC)) u_timer (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_entry_i (load_entry),
      .load_exit_i  (load_exit),
      .done_o       (timer_done)
   );

   snz_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_sync_i   (req_sync),
      .timer_done_i (timer_done),
      .load_entry_o (load_entry),
      .load_exit_o  (load_exit),
      .state_o      (state)
   );

   snz_guard u_guard (
      .clk         (clk),
      .rst_n       (rst_n),
      .state_i     (state),
      .acc_valid_i (acc_valid_i),
      .acc_write_i (acc_write_i),
      .err_o       (proto_err_o)
   );

   assign ready_o     = (state == SNZ_READY);
   assign in_ignore_o = (state == SNZ_SLEEP);
   assign pwr_down_o  = (state == SNZ_SLEEP);
   assign q_hiz_o     = (state != SNZ_READY);

   AST_NO_SLEEP_WHILE_READY: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |=> !pwr_down_o) else $error("sleep entered straight from ready"); // R2

   AST_HIZ_COVERS_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_down_o) |-> q_hiz_o) else $error("outputs driven on leaving sleep"); // R5

endmodule

// File: tb/tb_snz_seq.sv
module tb_snz_seq;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sleep_req = 1'b0;
   logic acc_valid = 1'b0;
   logic acc_write = 1'b0;
   logic ready, in_ignore, pwr_down, q_hiz, proto_err;

   always #2.5 clk = ~clk;

   snz_seq dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .sleep_req_i (sleep_req),
      .acc_valid_i (acc_valid),
      .acc_write_i (acc_write),
      .ready_o     (ready),
      .in_ignore_o (in_ignore),
      .pwr_down_o  (pwr_down),
      .q_hiz_o     (q_hiz),
      .proto_err_o (proto_err)
   );

   // expected {ready, ignore, pwr_down, hiz}
   localparam logic [3:0] RDY = 4'b1000;
   localparam logic [3:0] WIN = 4'b0001;
   localparam logic [3:0] SLP = 4'b0111;

   typedef struct packed { logic [3:0] outs; logic err; } exp_t;
   exp_t  exp_q[$];
   string tag_q[$];
   int    n_run  = 0;
   int    n_fail = 0;
   bit    finished = 1'b0;

   task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   // driver: sets inputs for the next edge and queues the result expected after it
   task automatic step(input logic r, input logic v, input logic w,
                       input logic [3:0] o, input logic e, input string tag);
      @(negedge clk);
      sleep_req = r; acc_valid = v; acc_write = w;
      exp_q.push_back('{outs: o, err: e});
      tag_q.push_back(tag);
   endtask

   // monitor: compares right after the edge the queued item refers to
   always @(posedge clk) begin
      #1;
      if (exp_q.size() != 0) begin
         exp_t  x;
         string t;
         x = exp_q.pop_front();
         t = tag_q.pop_front();
         check(t, {ready, in_ignore, pwr_down, q_hiz, proto_err}, {x.outs, x.err});
      end
   end

   task automatic drain();
      while (exp_q.size() != 0) @(posedge clk);
      #2;
   endtask

   task automatic apply_reset(input string tag);
      @(negedge clk);
      rst_n = 1'b0; sleep_req = 1'b0; acc_valid = 1'b0; acc_write = 1'b0;
      repeat (2) @(negedge clk);
      check(tag, {ready, in_ignore, pwr_down, q_hiz, proto_err}, {RDY, 1'b0});
      rst_n = 1'b1;
   endtask

   initial begin
      apply_reset("R1 reset values");
      step(0, 0, 0, RDY, 0, "R1 after release");

      // full entry, sleep, release
      step(1, 0, 0, RDY, 0, "R2 edge1 still ready");
      step(1, 0, 0, RDY, 0, "R2 edge2 still ready");
      step(1, 0, 0, WIN, 0, "R2 edge3 entry window");
      step(1, 1, 0, WIN, 0, "R3 R8 read in entry window");
      step(1, 0, 0, SLP, 0, "R3 sleep after two entry cycles");
      step(1, 1, 1, SLP, 0, "R8 write while asleep ignored");
      step(1, 0, 0, SLP, 0, "R4 sleep held");
      step(1, 0, 0, SLP, 0, "R4 sleep held");
      step(0, 0, 0, SLP, 0, "R5 release edge1");
      step(0, 0, 0, SLP, 0, "R5 release edge2");
      step(0, 0, 0, WIN, 0, "R5 recovery cycle1");
      step(0, 1, 0, WIN, 0, "R5 R8 read in recovery");
      step(0, 0, 0, RDY, 0, "R5 ready after recovery");
      step(0, 1, 1, RDY, 0, "R8 write while ready");
      drain();

      // one-cycle pulse: release seen inside the entry window
      step(1, 0, 0, RDY, 0, "R6 short pulse edge1");
      step(0, 0, 0, RDY, 0, "R6 short pulse edge2");
      step(0, 0, 0, WIN, 0, "R6 entry");
      step(0, 0, 0, WIN, 0, "R6 recovery1");
      step(0, 0, 0, WIN, 0, "R6 recovery2 full length");
      step(0, 0, 0, RDY, 0, "R6 back to ready");
      drain();

      // two-cycle pulse: release collides with entry expiry, write on same edge
      step(1, 0, 0, RDY, 0, "R6 collide edge1");
      step(1, 0, 0, RDY, 0, "R6 collide edge2");
      step(0, 0, 0, WIN, 0, "R6 collide entry1");
      step(0, 0, 0, WIN, 0, "R6 collide entry2");
      step(0, 1, 1, WIN, 1, "R6 R7 release wins, write flagged");
      step(0, 0, 0, WIN, 1, "R7 sticky in recovery");
      step(0, 0, 0, RDY, 1, "R7 sticky at ready");
      step(0, 0, 0, RDY, 1, "R7 sticky idle");
      drain();
      apply_reset("R1 R7 reset clears error");
      step(0, 0, 0, RDY, 0, "R1 ready after second reset");

      // write inside the recovery window
      step(1, 0, 0, RDY, 0, "R2 edge1");
      step(1, 0, 0, RDY, 0, "R2 edge2");
      step(1, 0, 0, WIN, 0, "R3 entry1");
      step(1, 0, 0, WIN, 0, "R3 entry2");
      step(0, 0, 0, SLP, 0, "R4 sleep");
      step(0, 0, 0, SLP, 0, "R4 sleep");
      step(0, 0, 0, WIN, 0, "R5 recovery1");
      step(0, 1, 1, WIN, 1, "R7 write in recovery flagged");
      step(0, 0, 0, RDY, 1, "R7 sticky after recovery");
      drain();

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule